// File: doc/BRIEF.md
# LED Output Controller with PWM

This peripheral drives a single LED pin and is programmed through an AHB-Lite slave port. Software writes a control word that turns the output on or off and chooses between two ways of driving it. The first is a fixed level chosen by a control bit. The second is a pulse-width-modulated waveform defined by a period register and a duty register. A read-only status word reports the level present on the pin at that moment.

The slave never stalls and never signals an error. It latches a transfer in the address phase. A write takes its data in the following cycle, and a read returns its data in that same following cycle. Inside the selected window, an address that matches none of the four word registers reads as zero, and writes to it are discarded. A free-running counter produces the PWM waveform. The counter is held at zero whenever PWM operation is not active, so every PWM run starts at the beginning of a period.

Top module: `led_pwm_periph`

## Requirements
- R1: After an active-low synchronous reset, control, period and duty read as zero, the LED output is low and the PWM counter is zero.
- R2: The control word sits at offset 0x0 and keeps only bits [2:0], where bit 0 is enable, bit 1 is mode and bit 2 is static level. All higher bits read as zero. Period (offset 0x8) and duty (offset 0xC) store and return all 32 bits. The window base is 0x60000000.
- R3: While control bit 0 is 0, the LED output is low whatever the other settings are.
- R4: With enable set and control bit 1 equal to 0, the LED follows control bit 2. Writing 0x01 gives low and writing 0x05 gives high.
- R5: The status word at offset 0x4 returns the current LED level in bit 0 and zero in every other bit. Writes to it change nothing.
- R6: With control bits 1 and 0 both set, the counter steps by one each clock and returns to zero in the clock after it reaches the period value, so the cycle lasts period+1 clocks. The LED is high while the counter is below duty.
- R7: In PWM mode a nonzero duty at or above the period keeps the LED constantly high, and a duty of zero keeps it constantly low.
- R8: Whenever PWM operation is not active, the counter is held at zero. Entering PWM mode therefore starts with the counter at 0 and the LED high for the first duty clocks.
- R9: A transfer is taken only when HSEL and HREADY are high and HTRANS is NONSEQ (2'b10) or SEQ (2'b11). A write commits HWDATA from the next cycle. IDLE, BUSY, deselected or not-ready cycles change nothing.
- R10: Addresses outside the four registers, and addresses that are not word-aligned, read as zero, and writes to them are ignored.
- R11: HREADYOUT is always 1 and HRESP is always 0 (OKAY).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Bus and PWM clock |
| hresetn | input | 1 | Synchronous active-low reset |
| hsel | input | 1 | Slave select |
| haddr | input | 32 | Transfer address |
| htrans | input | 2 | Transfer type |
| hwrite | input | 1 | 1 for write, 0 for read |
| hwdata | input | 32 | Write data, valid in the data phase |
| hready | input | 1 | Previous transfer complete on the bus |
| hrdata | output | 32 | Read data, valid in the data phase |
| hreadyout | output | 1 | Slave ready, constant 1 |
| hresp | output | 1 | Response, constant OKAY (0) |
| led_o | output | 1 | LED pin drive |

## Verification
The hardest point to reach from the ports is the restart of the PWM counter after operation has been paused. The counter cannot be read, so its being held at zero shows only as the exact phase of the waveform after PWM is re-enabled. The stimulus runs PWM, disables it for some cycles, re-enables it and then compares the LED clock by clock with a period/duty pattern that starts at count zero. It also checks the saturation edges, duty equal to the period and duty zero, and sends address phases with HREADY low, IDLE or HSEL low, whose lack of effect is then confirmed through readback.

// File: rtl/led_pwm_pkg.sv
// Shared definitions for the LED output controller.
// Assumes a 32-bit AHB-Lite style bus with word registers.
package led_pwm_pkg;

    typedef enum logic [1:0] {
        TR_IDLE   = 2'b00,
        TR_BUSY   = 2'b01,
        TR_NONSEQ = 2'b10,
        TR_SEQ    = 2'b11
    } trans_e;

    typedef enum logic [1:0] {
        RIX_CTRL   = 2'd0,
        RIX_STATUS = 2'd1,
        RIX_PERIOD = 2'd2,
        RIX_DUTY   = 2'd3
    } reg_idx_e;

    localparam int CTRL_W   = 3;
    localparam int CB_EN    = 0;
    localparam int CB_MODE  = 1;
    localparam int CB_LEVEL = 2;

endpackage

// File: rtl/ledp_bus_front.sv
// Address-phase capture for the AHB-Lite slave.
// Latches a qualified transfer and presents it in the data phase.
// Assumes word access; misaligned or out-of-window addresses are misses.
module ledp_bus_front
    import led_pwm_pkg::*;
#(
    parameter int              ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h6000_0000,
    parameter int              IDX_W     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        trans,
    input  logic              write,
    input  logic              ready_in,
    output logic              dp_wr,
    output logic              dp_rd,
    output logic [IDX_W-1:0]  dp_idx
);
    localparam int OFS_LSB = 2;
    localparam int WIN_LSB = OFS_LSB + IDX_W;

    logic take;
    logic hit;

    // Qualify the address phase and decode the register window.
    always_comb begin
        take = sel && ready_in && (trans == TR_NONSEQ || trans == TR_SEQ);
        hit  = (addr[ADDR_W-1:WIN_LSB] == BASE_ADDR[ADDR_W-1:WIN_LSB])
               && (addr[OFS_LSB-1:0] == '0);
    end

    // Register the decoded transfer for its data phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dp_wr  <= 1'b0;
            dp_rd  <= 1'b0;
            dp_idx <= '0;
        end else begin
            dp_wr  <= take && hit && write;
            dp_rd  <= take && hit && !write;
            dp_idx <= addr[WIN_LSB-1:OFS_LSB];
        end
    end
endmodule

// File: rtl/ledp_regs.sv
// Register storage and read multiplexer.
// Control keeps three bits; status is read-only and shows the live pin.
module ledp_regs
    import led_pwm_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              rd,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic              led_live,
    output logic [DATA_W-1:0] rdata,
    output logic [CTRL_W-1:0] ctrl,
    output logic [DATA_W-1:0] period,
    output logic [DATA_W-1:0] duty
);
    // Commit data-phase writes to the addressed register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl   <= '0;
            period <= '0;
            duty   <= '0;
        end else if (wr) begin
            case (reg_idx_e'(idx))
                RIX_CTRL:   ctrl   <= wdata[CTRL_W-1:0];
                RIX_PERIOD: period <= wdata;
                RIX_DUTY:   duty   <= wdata;
                default:    ;
            endcase
        end
    end

    // Select read data during a read data phase, zero otherwise.
    always_comb begin
        rdata = '0;
        if (rd) begin
            case (reg_idx_e'(idx))
                RIX_CTRL:   rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl};
                RIX_STATUS: rdata = {{(DATA_W-1){1'b0}}, led_live};
                RIX_PERIOD: rdata = period;
                RIX_DUTY:   rdata = duty;
                default:    rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/ledp_pwm.sv
// PWM counter and LED output selection.
// Counter runs 0..period only while enabled in PWM mode, else held at 0.
module ledp_pwm
    import led_pwm_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTRL_W-1:0] ctrl,
    input  logic [CNT_W-1:0]  period,
    input  logic [CNT_W-1:0]  duty,
    output logic [CNT_W-1:0]  cnt,
    output logic              led
);
    logic run;
    logic pwm_hi;

    // Decide run state and the PWM comparison result.
    always_comb begin
        run    = ctrl[CB_EN] && ctrl[CB_MODE];
        pwm_hi = (duty != '0) && ((duty >= period) || (cnt < duty));
    end

    // Advance, wrap or hold the period counter.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || cnt >= period)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    // Drive the pin from the enable, mode and level settings.
    always_comb begin
        if (!ctrl[CB_EN])
            led = 1'b0;
        else if (ctrl[CB_MODE])
            led = pwm_hi;
        else
            led = ctrl[CB_LEVEL];
    end
endmodule

// File: rtl/led_pwm_periph.sv
// LED output controller on an AHB-Lite slave port.
// Zero wait states, OKAY only; four word registers at BASE_ADDR.
module led_pwm_periph
    import led_pwm_pkg::*;
#(
    parameter int                ADDR_W    = 32,
    parameter int                DATA_W    = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h6000_0000
) (
    input  logic              hclk,
    input  logic              hresetn,
    input  logic              hsel,
    input  logic [ADDR_W-1:0] haddr,
    input  logic [1:0]        htrans,
    input  logic              hwrite,
    input  logic [DATA_W-1:0] hwdata,
    input  logic              hready,
    output logic [DATA_W-1:0] hrdata,
    output logic              hreadyout,
    output logic              hresp,
    output logic              led_o
);
    localparam int IDX_W = 2;

    logic              dp_wr;
    logic              dp_rd;
    logic [IDX_W-1:0]  dp_idx;
    logic [CTRL_W-1:0] ctrl_q;
    logic [DATA_W-1:0] period_q;
    logic [DATA_W-1:0] duty_q;
    logic [DATA_W-1:0] pwm_cnt;

    ledp_bus_front #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .IDX_W(IDX_W)) u_front (
        .clk(hclk), .rst_n(hresetn), .sel(hsel), .addr(haddr), .trans(htrans),
        .write(hwrite), .ready_in(hready), .dp_wr(dp_wr), .dp_rd(dp_rd), .dp_idx(dp_idx)
    );

    ledp_regs #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_regs (
        .clk(hclk), .rst_n(hresetn), .wr(dp_wr), .rd(dp_rd), .idx(dp_idx),
        .wdata(hwdata), .led_live(led_o), .rdata(hrdata), .ctrl(ctrl_q),
        .period(period_q), .duty(duty_q)
    );

    ledp_pwm #(.CNT_W(DATA_W)) u_pwm (
        .clk(hclk), .rst_n(hresetn), .ctrl(ctrl_q), .period(period_q),
        .duty(duty_q), .cnt(pwm_cnt), .led(led_o)
    );

    // Fixed response: never stall, never error.
    always_comb begin
        hreadyout = 1'b1;
        hresp     = 1'b0;
    end
endmodule

// File: rtl/led_pwm_checker.sv
// Property checker for the LED controller, attached by bind.
module led_pwm_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        ctrl,
    input logic [DATA_W-1:0] period,
    input logic [DATA_W-1:0] duty,
    input logic [DATA_W-1:0] cnt,
    input logic              led,
    input logic              readyout,
    input logic              resp
);
    a_r11_always_okay: assert property (@(posedge clk) disable iff (!rst_n)
        readyout && !resp);

    a_r3_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl[0] |-> !led);

    a_r8_cnt_held: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctrl[0] && ctrl[1]) |=> cnt == '0);

    a_r6_cnt_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt >= period) |=> cnt == '0);

    a_r6_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[0] && ctrl[1] && cnt < period) |=> cnt == $past(cnt) + 1'b1);

    a_r7_duty_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[0] && ctrl[1] && duty == '0) |-> !led);

    a_r4_static_level: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[0] && !ctrl[1]) |-> led == ctrl[2]);
endmodule

bind led_pwm_periph led_pwm_checker #(.DATA_W(DATA_W)) u_chk (
    .clk(hclk), .rst_n(hresetn), .ctrl(ctrl_q), .period(period_q),
    .duty(duty_q), .cnt(pwm_cnt), .led(led_o), .readyout(hreadyout), .resp(hresp)
);

// File: tb/sim_led_pwm_periph.sv
module sim_led_pwm_periph;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] BASE = 32'h6000_0000;

    logic        clk = 1'b0;
    logic        hresetn = 1'b0;
    logic        hsel = 1'b0;
    logic [31:0] haddr = '0;
    logic [1:0]  htrans = 2'b00;
    logic        hwrite = 1'b0;
    logic [31:0] hwdata = '0;
    logic        hready = 1'b1;
    logic [31:0] hrdata;
    logic        hreadyout;
    logic        hresp;
    logic        led_o;

    int n_chk = 0;
    int n_bad = 0;
    logic mon_on = 1'b0;
    logic done = 1'b0;

    typedef struct { string tag; logic [31:0] val; } exp_t;
    exp_t exp_q[$];

    // Bench-side register model
    logic [2:0]  m_ctrl = '0;
    logic [31:0] m_period = '0;
    logic [31:0] m_duty = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    led_pwm_periph u0 (
        .hclk(clk), .hresetn(hresetn), .hsel(hsel), .haddr(haddr), .htrans(htrans),
        .hwrite(hwrite), .hwdata(hwdata), .hready(hready), .hrdata(hrdata),
        .hreadyout(hreadyout), .hresp(hresp), .led_o(led_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic static_led();
        return m_ctrl[0] && !m_ctrl[1] && m_ctrl[2];
    endfunction

    function automatic logic in_win(input logic [31:0] a);
        return (a[31:4] == BASE[31:4]) && (a[1:0] == 2'b00);
    endfunction

    // Scoreboard monitor: compares read data in each read data phase
    always @(negedge clk) begin
        #(CLK_PERIOD/4);
        if (mon_on) begin
            exp_t e;
            e = exp_q.pop_front();
            chk(e.tag, hrdata, e.val);
        end
    end

    task automatic xfer(input logic wr, input logic [31:0] addr, input logic [31:0] data,
                        input string tag, input logic sel = 1'b1,
                        input logic [1:0] trans = 2'b10, input logic rdy = 1'b1);
        logic valid;
        exp_t e;
        valid = sel && rdy && trans[1] && in_win(addr);
        @(negedge clk);
        hsel = sel; haddr = addr; hwrite = wr; htrans = trans; hready = rdy;
        @(negedge clk);
        hsel = 1'b0; htrans = 2'b00; hready = 1'b1; hwrite = 1'b0; haddr = '0;
        hwdata = wr ? data : '0;
        if (!wr) begin
            e.tag = tag;
            e.val = '0;
            if (valid) begin
                case (addr[3:2])
                    2'd0: e.val = {29'b0, m_ctrl};
                    2'd1: e.val = {31'b0, static_led()};
                    2'd2: e.val = m_period;
                    default: e.val = m_duty;
                endcase
            end
            exp_q.push_back(e);
            mon_on = 1'b1;
        end
        @(posedge clk);
        if (wr && valid) begin
            case (addr[3:2])
                2'd0: m_ctrl = data[2:0];
                2'd2: m_period = data;
                2'd3: m_duty = data;
                default: ;
            endcase
        end
        @(negedge clk);
        mon_on = 1'b0;
    endtask

    task automatic pwm_pattern(input string tag, input int cycles);
        for (int k = 0; k < cycles; k++) begin
            logic e;
            if (k > 0) @(negedge clk);
            if (m_duty == 0) e = 1'b0;
            else if (m_duty >= m_period) e = 1'b1;
            else e = (k % (m_period + 1)) < m_duty;
            chk(tag, {31'b0, led_o}, {31'b0, e});
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        hresetn = 1'b1;
        // R1 reset state
        chk("R1 led after reset", {31'b0, led_o}, 32'h0);
        chk("R11 readyout", {31'b0, hreadyout}, 32'h1);
        chk("R11 resp", {31'b0, hresp}, 32'h0);
        xfer(1'b0, BASE + 32'h0, '0, "R1 ctrl reset");
        xfer(1'b0, BASE + 32'h8, '0, "R1 period reset");
        xfer(1'b0, BASE + 32'hC, '0, "R1 duty reset");

        // R4 static mode levels
        xfer(1'b1, BASE, 32'h5, "");
        chk("R4 static high", {31'b0, led_o}, 32'h1);
        xfer(1'b0, BASE + 32'h4, '0, "R5 status high");
        xfer(1'b1, BASE + 32'h4, 32'hFFFF_FFFF, "");
        xfer(1'b0, BASE + 32'h4, '0, "R5 status write ignored");
        xfer(1'b1, BASE, 32'h1, "");
        chk("R4 static low", {31'b0, led_o}, 32'h0);
        xfer(1'b0, BASE + 32'h4, '0, "R5 status low");

        // R2 control width and full period/duty
        xfer(1'b1, BASE, 32'hFFFF_FFFD, "");
        xfer(1'b0, BASE, '0, "R2 ctrl upper bits zero");
        xfer(1'b1, BASE + 32'h8, 32'hA5C3_0F12, "");
        xfer(1'b1, BASE + 32'hC, 32'h5A3C_F0ED, "");
        xfer(1'b0, BASE + 32'h8, '0, "R2 period readback");
        xfer(1'b0, BASE + 32'hC, '0, "R2 duty readback");

        // R3 disable forces low even with level and pwm settings
        xfer(1'b1, BASE, 32'h4, "");
        chk("R3 disabled low", {31'b0, led_o}, 32'h0);
        repeat (3) @(negedge clk);
        chk("R3 disabled stays low", {31'b0, led_o}, 32'h0);

        // R9 unqualified transfers change nothing
        xfer(1'b1, BASE, 32'h5, "", 1'b1, 2'b10, 1'b0);
        xfer(1'b1, BASE, 32'h5, "", 1'b1, 2'b00, 1'b1);
        xfer(1'b1, BASE, 32'h5, "", 1'b1, 2'b01, 1'b1);
        xfer(1'b1, BASE, 32'h5, "", 1'b0, 2'b10, 1'b1);
        chk("R9 ignored writes keep led", {31'b0, led_o}, 32'h0);
        xfer(1'b0, BASE, '0, "R9 ctrl unchanged");
        xfer(1'b1, BASE, 32'h5, "", 1'b1, 2'b11, 1'b1);
        chk("R9 SEQ write taken", {31'b0, led_o}, 32'h1);

        // R10 out-of-window and misaligned
        xfer(1'b1, BASE + 32'h10, 32'hFFFF_FFFF, "");
        xfer(1'b1, BASE + 32'h9, 32'h0000_0001, "");
        xfer(1'b0, BASE + 32'h10, '0, "R10 out of range reads zero");
        xfer(1'b0, BASE + 32'h8, '0, "R10 period untouched");
        xfer(1'b0, BASE + 32'h1, '0, "R10 misaligned reads zero");

        // R6 pwm pattern: period 4, duty 2
        xfer(1'b1, BASE + 32'h8, 32'd4, "");
        xfer(1'b1, BASE + 32'hC, 32'd2, "");
        xfer(1'b1, BASE, 32'h3, "");
        pwm_pattern("R6 pwm period4 duty2", 12);

        // R8 pause then restart from zero
        xfer(1'b1, BASE, 32'h2, "");
        chk("R8 paused low", {31'b0, led_o}, 32'h0);
        repeat (7) @(negedge clk);
        xfer(1'b1, BASE, 32'h3, "");
        pwm_pattern("R8 restart at zero", 10);
        xfer(1'b1, BASE, 32'h1, "");
        xfer(1'b1, BASE + 32'h8, 32'd6, "");
        xfer(1'b1, BASE + 32'hC, 32'd5, "");
        repeat (2) @(negedge clk);
        xfer(1'b1, BASE, 32'h3, "");
        pwm_pattern("R8 restart period6 duty5", 14);

        // R7 saturation edges
        xfer(1'b1, BASE + 32'hC, 32'd6, "");
        pwm_pattern("R7 duty equal period high", 9);
        xfer(1'b1, BASE + 32'hC, 32'd900, "");
        pwm_pattern("R7 duty above period high", 9);
        xfer(1'b1, BASE + 32'hC, 32'd0, "");
        pwm_pattern("R7 duty zero low", 9);

        chk("R11 readyout end", {31'b0, hreadyout}, 32'h1);
        chk("R11 resp end", {31'b0, hresp}, 32'h0);
        done = 1'b1;
        finish_run();
    end
endmodule